// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Hardware Refill

This block translates virtual addresses into physical addresses for a load/store unit. It keeps a fully associative set of recent translations. Each one is tagged with the address-space number of the context that loaded it. Because of that tag, translations from several contexts can sit in the buffer together, and a context switch only needs the caller to present a new address-space number. On every hit the stored permission bits are checked against the access type. A write to a non-writable page, or a user-mode access to a kernel-only page, is reported as a protection fault.

When no stored translation matches, a small walker issues one read of the page-table entry. The entry's address is the page-table base plus the virtual page number times four. When the entry comes back valid, the walker installs it and the translation completes. When the entry comes back invalid, the walker reports a page fault and installs nothing. The victim slot is the lowest-numbered empty slot if one exists; otherwise a round-robin pointer picks it. A single-cycle invalidate-all input empties the buffer.

The caller raises `reqValid` with the address, address-space number and access type, and holds all of them stable until `respValid` pulses. A hit answers in the same cycle the request is seen while the block is idle.

Top module: `asn_tlb`

## Requirements
- R1: The physical address is the stored physical page number (address bits 31:13) concatenated with the untranslated low 13 bits of the virtual address.
- R2: A request hits only when some entry is valid and matches both the virtual page number (virtual address bits 31:13) and the request's address-space number. A hit answers with respValid=1, respHit=1 and respMiss=0 in the cycle the idle block sees the request, and issues no memory read.
- R3: Entries loaded under different address-space numbers coexist. The same virtual page under another number misses, and returning to the first number hits again without any flush.
- R4: On a miss, exactly one single-cycle memory read (memReqValid) is issued, in the cycle after the miss is seen. Its address is ptBase + virtual page number × 4.
- R5: A returned entry has bit 0 = valid, bit 1 = writable, bit 2 = user-accessible, and bits 31:13 = physical page number. A valid entry is installed, and the translation then completes with respHit=0 and respMiss=1.
- R6: respProtFault is set when a write targets a page whose writable bit is clear, or a user access targets a page whose user bit is clear. Kernel reads never fault on protection.
- R7: A returned entry with bit 0 clear completes the request with respPageFault=1 and respMiss=1 and is not installed, so repeating the access issues a new memory read.
- R8: invAll clears every entry in one cycle, and takes precedence over an install in the same cycle. The next access to any page misses.
- R9: While an empty slot exists, a refill uses the lowest-numbered empty slot and evicts nothing.
- R10: When all slots are full, the victim is chosen by a round-robin pointer. The pointer is 0 after reset, advances by one each time it is used, and is not changed by invAll.
- R11: After reset the buffer is empty and neither respValid nor memReqValid is asserted while reqValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Translation request, held until respValid |
| reqVa | input | 32 | Virtual address |
| reqAsn | input | 8 | Address-space number of the request |
| reqWrite | input | 1 | 1 = write access, 0 = read |
| reqUser | input | 1 | 1 = user-mode access, 0 = kernel |
| ptBase | input | 32 | Page-table base address |
| invAll | input | 1 | Invalidate every entry |
| memReqValid | output | 1 | One-cycle page-table-entry read request |
| memReqAddr | output | 32 | Address of the page-table entry |
| memRspValid | input | 1 | Page-table-entry data valid |
| memRspData | input | 32 | Page-table entry |
| respValid | output | 1 | Translation complete |
| respPa | output | 32 | Physical address |
| respHit | output | 1 | Completed from a stored entry without refill |
| respMiss | output | 1 | Completed after a page-table read |
| respProtFault | output | 1 | Permission violation |
| respPageFault | output | 1 | Page-table entry was invalid |

## Verification
The assertions assume the requester holds reqValid, reqVa, reqAsn, reqWrite, reqUser and ptBase steady from the request until respValid. They also assume the memory side returns exactly one memRspValid pulse for each memReqValid pulse, and never returns one otherwise. The bench keeps to this by issuing every access through one task: the task drives all request fields at a falling edge, holds them until the response, then drops reqValid. A single memory model in that task answers each read once, after a fixed delay, with an entry computed from the read address.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_WRITE_BIT = 1;
  localparam int PTE_USER_BIT  = 2;

  typedef struct packed {
    logic install;
    logic flushAll;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walkState_e;

endpackage

// File: rtl/tlb_dpath.sv
module tlb_dpath
  import tlb_pkg::*;
#(
  parameter int ENTRIES   = 128,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int ASN_W     = 8,
  parameter int PAGE_BITS = 13,
  parameter int PTE_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  logic [VA_W-1:0]  reqVa,
  input  logic [ASN_W-1:0] reqAsn,
  input  logic             reqWrite,
  input  logic             reqUser,
  input  logic [PA_W-1:0]  ptBase,
  input  logic [PA_W-1:0]  pteData,
  output logic             lookupHit,
  output logic             protFault,
  output logic [PA_W-1:0]  physAddr,
  output logic [PA_W-1:0]  pteAddr
);
  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int PPN_W     = PA_W - PAGE_BITS;
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int PTE_SHIFT = $clog2(PTE_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] entValid;
  logic [VPN_W-1:0]   entVpn [ENTRIES];
  logic [ASN_W-1:0]   entAsn [ENTRIES];
  logic [PPN_W-1:0]   entPpn [ENTRIES];
  logic [ENTRIES-1:0] entWr;
  logic [ENTRIES-1:0] entUsr;

  logic [ENTRIES-1:0] matchVec;
  logic [VPN_W-1:0]   reqVpn;
  logic [PPN_W-1:0]   hitPpn;
  logic               hitWr, hitUsr;
  logic               haveFree;
  logic [IDX_W-1:0]   freeIdx, rrPtr, victimIdx;

  assign reqVpn = reqVa[VA_W-1:PAGE_BITS];

  // Parallel tag compare, one comparator per slot.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = entValid[g] && (entVpn[g] == reqVpn) && (entAsn[g] == reqAsn);
  end

  // OR-mux of the matching slot's payload (at most one slot matches).
  always_comb begin
    hitPpn = '0;
    hitWr  = 1'b0;
    hitUsr = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) begin
        hitPpn = hitPpn | entPpn[i];
        hitWr  = hitWr  | entWr[i];
        hitUsr = hitUsr | entUsr[i];
      end
    end
  end

  assign lookupHit = |matchVec;
  assign protFault = lookupHit && ((reqWrite && !hitWr) || (reqUser && !hitUsr));
  assign physAddr  = {hitPpn, reqVa[PAGE_BITS-1:0]};
  assign pteAddr   = ptBase + (PA_W'(reqVpn) << PTE_SHIFT);

  // Lowest-numbered empty slot.
  always_comb begin
    haveFree = 1'b0;
    freeIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!entValid[i]) begin
        haveFree = 1'b1;
        freeIdx  = IDX_W'(i);
      end
    end
  end

  assign victimIdx = haveFree ? freeIdx : rrPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      rrPtr    <= '0;
    end else if (strb.flushAll) begin
      entValid <= '0;
    end else if (strb.install) begin
      entValid[victimIdx] <= 1'b1;
      if (!haveFree) rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.install && !strb.flushAll) begin
      entVpn[victimIdx] <= reqVpn;
      entAsn[victimIdx] <= reqAsn;
      entPpn[victimIdx] <= pteData[PA_W-1:PAGE_BITS];
      entWr[victimIdx]  <= pteData[PTE_WRITE_BIT];
      entUsr[victimIdx] <= pteData[PTE_USER_BIT];
    end
  end

  // R2: tags never alias, so a lookup selects at most one slot.
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  // R8: a flush leaves no slot valid on the following cycle.
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushAll |=> (entValid == '0));

  // R9: a refill into an empty slot grows the occupancy by exactly one.
  a_r9_no_evict_when_free: assert property (@(posedge clk) disable iff (!rstN)
    (strb.install && !strb.flushAll && haveFree)
      |=> ($countones(entValid) == $past($countones(entValid)) + 1));

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       invAll,
  input  logic       lookupHit,
  input  logic       protFault,
  input  logic       memRspValid,
  input  logic       pteValid,
  output ctlStrobe_t strb,
  output logic       memReqValid,
  output logic       respValid,
  output logic       respHit,
  output logic       respMiss,
  output logic       respProtFault,
  output logic       respPageFault
);
  walkState_e state, stateNext;
  logic       refilled, refilledNext;

  always_comb begin
    stateNext     = state;
    refilledNext  = refilled;
    strb.flushAll = invAll;
    strb.install  = 1'b0;
    memReqValid   = 1'b0;
    respValid     = 1'b0;
    respHit       = 1'b0;
    respMiss      = 1'b0;
    respProtFault = 1'b0;
    respPageFault = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (lookupHit) begin
            respValid     = 1'b1;
            respHit       = !refilled;
            respMiss      = refilled;
            respProtFault = protFault;
            refilledNext  = 1'b0;
          end else begin
            stateNext = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        memReqValid = 1'b1;
        stateNext   = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          stateNext = ST_IDLE;
          if (pteValid) begin
            strb.install = 1'b1;
            refilledNext = 1'b1;
          end else begin
            respValid     = 1'b1;
            respMiss      = 1'b1;
            respPageFault = 1'b1;
            refilledNext  = 1'b0;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      refilled <= 1'b0;
    end else begin
      state    <= stateNext;
      refilled <= refilledNext;
    end
  end

  // R4: a page-table read is a single-cycle pulse.
  a_r4_one_cycle_read: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R4: a read only starts after a request that missed.
  a_r4_read_follows_miss: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReqValid) |-> $past(reqValid && !lookupHit));

  // R7: a page fault ends the walk and returns to idle.
  a_r7_fault_ends_walk: assert property (@(posedge clk) disable iff (!rstN)
    respPageFault |=> (state == ST_IDLE));

  // R5: an installed entry is answered without a second read.
  a_r5_install_no_reread: assert property (@(posedge clk) disable iff (!rstN)
    strb.install |=> !memReqValid);

endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES   = 128,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int ASN_W     = 8,
  parameter int PAGE_BITS = 13,
  parameter int PTE_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqVa,
  input  logic [ASN_W-1:0] reqAsn,
  input  logic             reqWrite,
  input  logic             reqUser,
  input  logic [PA_W-1:0]  ptBase,
  input  logic             invAll,
  output logic             memReqValid,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic [PA_W-1:0]  memRspData,
  output logic             respValid,
  output logic [PA_W-1:0]  respPa,
  output logic             respHit,
  output logic             respMiss,
  output logic             respProtFault,
  output logic             respPageFault
);
  ctlStrobe_t strb;
  logic       lookupHit, protFault;

  tlb_dpath #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASN_W(ASN_W),
    .PAGE_BITS(PAGE_BITS), .PTE_BYTES(PTE_BYTES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqVa(reqVa), .reqAsn(reqAsn), .reqWrite(reqWrite), .reqUser(reqUser),
    .ptBase(ptBase), .pteData(memRspData),
    .lookupHit(lookupHit), .protFault(protFault),
    .physAddr(respPa), .pteAddr(memReqAddr)
  );

  tlb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .invAll(invAll),
    .lookupHit(lookupHit), .protFault(protFault),
    .memRspValid(memRspValid), .pteValid(memRspData[PTE_VALID_BIT]),
    .strb(strb), .memReqValid(memReqValid),
    .respValid(respValid), .respHit(respHit), .respMiss(respMiss),
    .respProtFault(respProtFault), .respPageFault(respPageFault)
  );

endmodule

// File: tb/asn_tlb_tb.sv
module asn_tlb_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVa = '0;
  logic [7:0]  reqAsn = '0;
  logic        reqWrite = 1'b0, reqUser = 1'b0;
  logic [31:0] ptBase = '0;
  logic        invAll = 1'b0;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        respValid;
  logic [31:0] respPa;
  logic        respHit, respMiss, respProtFault, respPageFault;

  int nChecks = 0;
  int nFail = 0;

  // translation results
  logic        oHit, oMiss, oProt, oPf;
  logic [31:0] oPa, oAddr;
  int          oReqs;

  always #5 clk = ~clk;

  asn_tlb u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa), .reqAsn(reqAsn),
    .reqWrite(reqWrite), .reqUser(reqUser), .ptBase(ptBase), .invAll(invAll),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .respValid(respValid), .respPa(respPa), .respHit(respHit), .respMiss(respMiss),
    .respProtFault(respProtFault), .respPageFault(respPageFault)
  );

  function automatic logic [18:0] ppnOf(logic [7:0] asn, logic [18:0] vpn);
    return vpn ^ {asn, 11'h2A5};
  endfunction

  function automatic logic [31:0] baseOf(logic [7:0] asn);
    return {asn, 24'h0};
  endfunction

  // page table: valid below 0x7F000, writable = vpn[0], user = vpn[1]
  function automatic logic [31:0] pteAt(logic [31:0] addr);
    logic [7:0]  asn = addr[31:24];
    logic [18:0] vpn = addr[20:2];
    return {ppnOf(asn, vpn), 10'b0, vpn[1], vpn[0], (vpn < 19'h7F000)};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic translate(input logic [18:0] vpn, input logic [12:0] off, input logic [7:0] asn,
                           input logic wr, input logic usr);
    int cd = 0;
    logic done = 1'b0;
    @(negedge clk);
    reqVa = {vpn, off}; reqAsn = asn; reqWrite = wr; reqUser = usr;
    ptBase = baseOf(asn); reqValid = 1'b1;
    oReqs = 0; oAddr = '0;
    for (int k = 0; k < 40 && !done; k++) begin
      #1;
      if (memReqValid) begin oReqs++; oAddr = memReqAddr; cd = 2; end
      if (respValid) begin
        done = 1'b1;
        oHit = respHit; oMiss = respMiss; oProt = respProtFault;
        oPf = respPageFault; oPa = respPa;
      end
      @(negedge clk);
      memRspValid = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin memRspValid = 1'b1; memRspData = pteAt(oAddr); end
      end
    end
    reqValid = 1'b0;
    memRspValid = 1'b0;
    if (!done) chk(1'b0, "R2 no response", 32'd0, 32'd1);
  endtask

  task automatic flushAll();
    @(negedge clk); invAll = 1'b1;
    @(negedge clk); invAll = 1'b0;
  endtask

  // expect a completed access with hit (1) or refill (0)
  task automatic expectAccess(input logic [18:0] vpn, input logic [7:0] asn, input logic expHit, input string req);
    translate(vpn, 13'h0ABC, asn, 1'b0, 1'b0);
    chk(oHit == expHit && oMiss == !expHit && oReqs == (expHit ? 0 : 1), req, {oHit, oMiss, 30'(oReqs)}, {expHit, !expHit, 30'(expHit ? 0 : 1)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int hits;
    logic [31:0] seedDummy;
    seedDummy = $urandom(32'd7);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(!respValid && !memReqValid, "R11 idle after reset", {respValid, memReqValid}, 0);

    // R4 R5 R1: first access refills
    translate(19'd5, 13'h1234, 8'd1, 1'b0, 1'b0);
    chk(oReqs == 1 && oAddr == baseOf(8'd1) + 32'd20, "R4 walk address", oAddr, baseOf(8'd1) + 32'd20);
    chk(!oHit && oMiss && !oPf, "R5 refill completes", {oHit, oMiss, oPf}, 3'b010);
    chk(oPa == {ppnOf(8'd1, 19'd5), 13'h1234}, "R1 physical address", oPa, {ppnOf(8'd1, 19'd5), 13'h1234});
    // R2 second access hits
    translate(19'd5, 13'h0007, 8'd1, 1'b0, 1'b0);
    chk(oHit && !oMiss && oReqs == 0, "R2 hit no read", {oHit, oMiss, 30'(oReqs)}, {2'b10, 30'd0});
    chk(oPa == {ppnOf(8'd1, 19'd5), 13'h0007}, "R1 hit address", oPa, {ppnOf(8'd1, 19'd5), 13'h0007});
    // R3 other address space
    translate(19'd5, 13'h0, 8'd2, 1'b0, 1'b0);
    chk(!oHit && oReqs == 1 && oPa == {ppnOf(8'd2, 19'd5), 13'h0}, "R3 other asn misses", oPa, {ppnOf(8'd2, 19'd5), 13'h0});
    expectAccess(19'd5, 8'd1, 1'b1, "R3 first asn still resident");
    expectAccess(19'd5, 8'd2, 1'b1, "R3 second asn resident");
    // R6 protection
    translate(19'd5, 13'h0, 8'd1, 1'b0, 1'b1);
    chk(oProt, "R6 user read of kernel page", oProt, 1);
    translate(19'd4, 13'h0, 8'd1, 1'b1, 1'b0);
    chk(oProt && oMiss, "R6 write to read-only page", oProt, 1);
    translate(19'd4, 13'h0, 8'd1, 1'b0, 1'b0);
    chk(!oProt && oHit, "R6 kernel read allowed", oProt, 0);
    translate(19'd7, 13'h0, 8'd1, 1'b1, 1'b1);
    chk(!oProt, "R6 user write to user writable page", oProt, 0);
    // R7 page fault
    translate(19'h7F123, 13'h0, 8'd1, 1'b0, 1'b0);
    chk(oPf && oMiss && !oHit && oReqs == 1, "R7 page fault", {oPf, oMiss, oHit}, 3'b110);
    translate(19'h7F123, 13'h0, 8'd1, 1'b0, 1'b0);
    chk(oPf && oReqs == 1, "R7 not installed", oReqs, 1);
    // R8 invalidate all
    flushAll();
    expectAccess(19'd5, 8'd1, 1'b0, "R8 miss after flush");
    expectAccess(19'd5, 8'd2, 1'b0, "R8 other asn flushed");

    // R9 R10 replacement
    flushAll();
    for (int v = 0; v < 128; v++) translate(19'(v), 13'h0, 8'd3, 1'b0, 1'b0);
    hits = 0;
    for (int v = 0; v < 128; v++) begin
      translate(19'(v), 13'h0, 8'd3, 1'b0, 1'b0);
      if (oHit) hits++;
    end
    chk(hits == 128, "R9 all slots filled without eviction", hits, 128);
    expectAccess(19'd200, 8'd3, 1'b0, "R10 new page when full");
    expectAccess(19'd1, 8'd3, 1'b1, "R10 slot1 kept");
    expectAccess(19'd0, 8'd3, 1'b0, "R10 slot0 evicted first");
    expectAccess(19'd1, 8'd3, 1'b0, "R10 pointer advanced to slot1");
    flushAll();
    for (int v = 0; v < 128; v++) translate(19'(v), 13'h0, 8'd3, 1'b0, 1'b0);
    hits = 0;
    for (int v = 0; v < 128; v++) begin
      translate(19'(v), 13'h0, 8'd3, 1'b0, 1'b0);
      if (oHit) hits++;
    end
    chk(hits == 128, "R9 empty slots preferred", hits, 128);
    expectAccess(19'd300, 8'd3, 1'b0, "R10 refill after flush");
    expectAccess(19'd2, 8'd3, 1'b1, "R10 slot2 kept");
    expectAccess(19'd3, 8'd3, 1'b0, "R10 pointer survives flush");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [18:0] v = 19'($urandom % 256);
      logic [7:0]  a = 8'(1 + $urandom % 3);
      logic [12:0] o = 13'($urandom);
      logic w = 1'($urandom);
      logic u = 1'($urandom);
      translate(v, o, a, w, u);
      chk(oPa == {ppnOf(a, v), o}, "R1 random address", oPa, {ppnOf(a, v), o});
      chk(oProt == ((w && !v[0]) || (u && !v[1])) && !oPf, "R6 random protection", {oProt, oPf}, {((w && !v[0]) || (u && !v[1])), 1'b0});
      chk((oHit == (oReqs == 0)) && (oMiss == (oReqs == 1)) && (oReqs == 0 || oAddr == baseOf(a) + {11'b0, v, 2'b0}),
          "R2 R4 random hit/read", oAddr, baseOf(a) + {11'b0, v, 2'b0});
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule